// File: doc/BRIEF.md
# Sixteen-Pointer Register File with Program and Data Selectors

This block is a scratchpad of sixteen 16-bit pointer registers. None of them is a dedicated program counter or data pointer. Two 4-bit selector registers name the register that currently acts as the program counter and the register that currently acts as the implicit data pointer. Software changes either selector with one operation, so a subroutine can run on its own program-counter register and return by switching the selector back.

Each cycle, one access address is produced combinationally. It comes from the register named by the program-counter selector, the data-pointer selector, or an explicit index. The access can leave that register unchanged, step it up by one after use (loads and pops), or step it down by one before use (pushes). A separate step port adds or subtracts one from any register. A byte port reads or writes either half of any register, so the file also serves as thirty-two 8-bit registers. Memory and instruction decode are outside the block.

Top module: `ptr_regfile`

## Requirements
- R1: A cycle with `rst` high clears both selectors and register 0 to zero. After reset an access through the program-counter selector (`acc_src`=0) gives address 0x0000.
- R2: `step_op`=1 adds one to register `step_idx` and `step_op`=2 subtracts one, as a full 16-bit value with carry or borrow across the byte halves, visible the next cycle. `step_op` values 0 and 3 do nothing.
- R3: `half_we` writes `half_wdata` into bits 15:8 of register `half_idx` when `half_hi`=1, or into bits 7:0 when `half_hi`=0, leaving the other half unchanged. `half_rdata` shows the half that `half_idx` and `half_hi` select, combinationally.
- R4: `set_p_en` loads `p_val` into the program-counter selector `p_sel`. From the next cycle, `acc_src`=0 addresses through that register. The selector holds its value otherwise.
- R5: `set_x_en` loads `x_val` into the data-pointer selector `x_sel`. From the next cycle, `acc_src`=1 addresses through that register. The selector holds its value otherwise.
- R6: `acc_mode`=1 (post-increment) puts the selected register's current value on `acc_addr`. The register holds that value plus one in the next cycle. `acc_src`=2 or 3 selects register `acc_idx`.
- R7: `acc_mode`=2 (pre-decrement) puts the selected register's value minus one on `acc_addr` in the same cycle. The register holds that decremented value in the next cycle.
- R8: On the same register in the same cycle, a half write overrides a step, and a step overrides an access adjustment.
- R9: `acc_mode`=0 or 3 puts the selected register's value on `acc_addr` and leaves that register unchanged.
- R10: Stepping up wraps 0xFFFF to 0x0000, and stepping down wraps 0x0000 to 0xFFFF. This applies to the step port and to access adjustments.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_p_en | input | 1 | Load program-counter selector |
| p_val | input | 4 | New program-counter selector value |
| set_x_en | input | 1 | Load data-pointer selector |
| x_val | input | 4 | New data-pointer selector value |
| step_op | input | 2 | 0 none, 1 increment, 2 decrement, 3 none |
| step_idx | input | 4 | Register stepped by the step port |
| half_we | input | 1 | Write one byte half |
| half_hi | input | 1 | 1 selects bits 15:8, 0 selects bits 7:0 |
| half_idx | input | 4 | Register for byte read and write |
| half_wdata | input | 8 | Byte to write |
| half_rdata | output | 8 | Selected byte of selected register |
| acc_src | input | 2 | 0 program-counter selector, 1 data-pointer selector, 2/3 explicit |
| acc_idx | input | 4 | Explicit register index |
| acc_mode | input | 2 | 0 plain, 1 post-increment, 2 pre-decrement, 3 plain |
| acc_addr | output | 16 | Access address |
| p_sel | output | 4 | Current program-counter selector |
| x_sel | output | 4 | Current data-pointer selector |

## Verification
`acc_addr` and `half_rdata` are combinational, so the bench reads them in the same cycle it drives the access. The bench drives inputs 1 ns after a rising edge and reads them shortly after. Register updates, selector loads and reset take effect at the next rising edge. Each of these is checked 1 ns after that edge, with the inputs already back to idle. Register contents are read back through a plain explicit access, which changes nothing.

// File: rtl/ptrfile_pkg.sv
package ptrfile_pkg;
    localparam int NUM_REGS = 16;
    localparam int WORD_W   = 16;
    localparam int HALF_W   = WORD_W / 2;
    localparam int IDX_W    = $clog2(NUM_REGS);

    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [HALF_W-1:0] half_t;

    typedef enum logic [1:0] {
        SRC_P = 2'd0, SRC_X = 2'd1, SRC_IDX = 2'd2, SRC_IDX_ALT = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        AM_PLAIN = 2'd0, AM_POSTINC = 2'd1, AM_PREDEC = 2'd2, AM_PLAIN_ALT = 2'd3
    } amode_e;

    typedef enum logic [1:0] {
        ST_NONE = 2'd0, ST_INC = 2'd1, ST_DEC = 2'd2, ST_NONE_ALT = 2'd3
    } step_e;

    // Full-word update request for one register
    typedef struct packed {
        logic  en;
        idx_t  idx;
        word_t val;
    } wupd_t;

    // Byte-half write request
    typedef struct packed {
        logic  en;
        logic  hi;
        idx_t  idx;
        half_t val;
    } hupd_t;

    function automatic word_t bump(word_t w, logic down);
        return down ? (w - word_t'(1)) : (w + word_t'(1));
    endfunction

    function automatic half_t pick_half(word_t w, logic hi);
        return hi ? w[WORD_W-1:HALF_W] : w[HALF_W-1:0];
    endfunction

    function automatic word_t merge_half(word_t w, logic hi, half_t b);
        return hi ? {b, w[HALF_W-1:0]} : {w[WORD_W-1:HALF_W], b};
    endfunction
endpackage

// File: rtl/ptr_sel.sv
module ptr_sel
    import ptrfile_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic set_p_en,
    input  idx_t p_val,
    input  logic set_x_en,
    input  idx_t x_val,
    output idx_t p_sel,
    output idx_t x_sel
);
    always_ff @(posedge clk) begin
        if (rst) begin
            p_sel <= '0;
            x_sel <= '0;
        end else begin
            if (set_p_en) p_sel <= p_val;
            if (set_x_en) x_sel <= x_val;
        end
    end
endmodule

// File: rtl/ptr_addr_gen.sv
module ptr_addr_gen
    import ptrfile_pkg::*;
(
    input  word_t [NUM_REGS-1:0] regs,
    input  idx_t                 p_sel,
    input  idx_t                 x_sel,
    input  logic [1:0]           acc_src,
    input  idx_t                 acc_idx,
    input  logic [1:0]           acc_mode,
    input  logic [1:0]           step_op,
    input  idx_t                 step_idx,
    output word_t                acc_addr,
    output wupd_t                adj,
    output wupd_t                step
);
    idx_t   tgt;
    word_t  cur;
    src_e   src;
    amode_e mode;
    step_e  sop;

    always_comb begin
        src  = src_e'(acc_src);
        mode = amode_e'(acc_mode);
        sop  = step_e'(step_op);
        unique case (src)
            SRC_P:   tgt = p_sel;
            SRC_X:   tgt = x_sel;
            default: tgt = acc_idx;
        endcase
        cur = regs[tgt];

        adj.idx = tgt;
        adj.en  = 1'b0;
        adj.val = cur;
        acc_addr = cur;
        unique case (mode)
            AM_POSTINC: begin
                adj.en  = 1'b1;
                adj.val = bump(cur, 1'b0);
            end
            AM_PREDEC: begin
                adj.en   = 1'b1;
                adj.val  = bump(cur, 1'b1);
                acc_addr = adj.val;
            end
            default: ;
        endcase

        step.idx = step_idx;
        step.en  = (sop == ST_INC) || (sop == ST_DEC);
        step.val = bump(regs[step_idx], sop == ST_DEC);
    end
endmodule

// File: rtl/ptr_bank.sv
module ptr_bank
    import ptrfile_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  hupd_t                hwr,
    input  wupd_t                step,
    input  wupd_t                adj,
    output word_t [NUM_REGS-1:0] regs
);
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        word_t nxt;
        logic  hit_h, hit_s, hit_a;

        always_comb begin
            hit_h = hwr.en  && (hwr.idx  == idx_t'(i));
            hit_s = step.en && (step.idx == idx_t'(i));
            hit_a = adj.en  && (adj.idx  == idx_t'(i));
            if (hit_h)      nxt = merge_half(regs[i], hwr.hi, hwr.val);
            else if (hit_s) nxt = step.val;
            else if (hit_a) nxt = adj.val;
            else            nxt = regs[i];
        end

        if (i == 0) begin : g_rst
            always_ff @(posedge clk) begin
                if (rst) regs[i] <= '0;
                else     regs[i] <= nxt;
            end
        end else begin : g_nrst
            always_ff @(posedge clk) begin
                regs[i] <= nxt;
            end
        end
    end
endmodule

// File: rtl/ptr_regfile.sv
module ptr_regfile
    import ptrfile_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        set_p_en,
    input  logic [3:0]  p_val,
    input  logic        set_x_en,
    input  logic [3:0]  x_val,
    input  logic [1:0]  step_op,
    input  logic [3:0]  step_idx,
    input  logic        half_we,
    input  logic        half_hi,
    input  logic [3:0]  half_idx,
    input  logic [7:0]  half_wdata,
    output logic [7:0]  half_rdata,
    input  logic [1:0]  acc_src,
    input  logic [3:0]  acc_idx,
    input  logic [1:0]  acc_mode,
    output logic [15:0] acc_addr,
    output logic [3:0]  p_sel,
    output logic [3:0]  x_sel
);
    word_t [NUM_REGS-1:0] regs;
    wupd_t adj, step;
    hupd_t hwr;

    assign hwr = '{en: half_we, hi: half_hi, idx: half_idx, val: half_wdata};
    assign half_rdata = pick_half(regs[half_idx], half_hi);

    ptr_sel u_sel (
        .clk(clk), .rst(rst),
        .set_p_en(set_p_en), .p_val(p_val),
        .set_x_en(set_x_en), .x_val(x_val),
        .p_sel(p_sel), .x_sel(x_sel)
    );

    ptr_addr_gen u_agen (
        .regs(regs), .p_sel(p_sel), .x_sel(x_sel),
        .acc_src(acc_src), .acc_idx(acc_idx), .acc_mode(acc_mode),
        .step_op(step_op), .step_idx(step_idx),
        .acc_addr(acc_addr), .adj(adj), .step(step)
    );

    ptr_bank u_bank (
        .clk(clk), .rst(rst), .hwr(hwr), .step(step), .adj(adj), .regs(regs)
    );
endmodule

// File: rtl/ptr_regfile_chk.sv
module ptr_regfile_chk
    import ptrfile_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 set_p_en,
    input logic [3:0]           p_val,
    input logic                 set_x_en,
    input logic [3:0]           x_val,
    input logic [1:0]           step_op,
    input logic [3:0]           step_idx,
    input logic                 half_we,
    input logic                 half_hi,
    input logic [3:0]           half_idx,
    input logic [7:0]           half_wdata,
    input logic [1:0]           acc_src,
    input logic [3:0]           acc_idx,
    input logic [1:0]           acc_mode,
    input logic [15:0]          acc_addr,
    input logic [3:0]           p_sel,
    input logic [3:0]           x_sel,
    input word_t [NUM_REGS-1:0] regs
);
    logic expl_clean;
    assign expl_clean = acc_src[1]
        && !(half_we && half_idx == acc_idx)
        && !((step_op == 2'd1 || step_op == 2'd2) && step_idx == acc_idx);

    assert_sel_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (p_sel == 4'd0 && x_sel == 4'd0));

    assert_p_load_R4: assert property (@(posedge clk) disable iff (rst)
        set_p_en |=> p_sel == $past(p_val));

    assert_p_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !set_p_en |=> $stable(p_sel));

    assert_x_load_R5: assert property (@(posedge clk) disable iff (rst)
        set_x_en |=> x_sel == $past(x_val));

    assert_postinc_R6: assert property (@(posedge clk) disable iff (rst)
        (expl_clean && acc_mode == 2'd1) |=>
            regs[$past(acc_idx)] == $past(acc_addr) + 16'd1);

    assert_predec_R7: assert property (@(posedge clk) disable iff (rst)
        (expl_clean && acc_mode == 2'd2) |=>
            regs[$past(acc_idx)] == $past(acc_addr));

    assert_half_hi_R3: assert property (@(posedge clk) disable iff (rst)
        (half_we && half_hi) |=> regs[$past(half_idx)][15:8] == $past(half_wdata));

    assert_half_lo_R3: assert property (@(posedge clk) disable iff (rst)
        (half_we && !half_hi) |=> regs[$past(half_idx)][7:0] == $past(half_wdata));

    assert_x_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !set_x_en |=> $stable(x_sel));
endmodule

bind ptr_regfile ptr_regfile_chk u_chk (.*);

// File: tb/ptr_regfile_bench.sv
`timescale 1ns/100ps
module ptr_regfile_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        set_p_en, set_x_en;
    logic [3:0]  p_val, x_val;
    logic [1:0]  step_op;
    logic [3:0]  step_idx;
    logic        half_we, half_hi;
    logic [3:0]  half_idx;
    logic [7:0]  half_wdata;
    logic [7:0]  half_rdata;
    logic [1:0]  acc_src, acc_mode;
    logic [3:0]  acc_idx;
    logic [15:0] acc_addr;
    logic [3:0]  p_sel, x_sel;

    int n_total = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    ptr_regfile u_ptr_regfile (.*);

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        set_p_en = 0; set_x_en = 0; p_val = 0; x_val = 0;
        step_op = 0; step_idx = 0;
        half_we = 0; half_hi = 0; half_idx = 0; half_wdata = 0;
        acc_src = 2; acc_idx = 0; acc_mode = 0;
    endtask

    // advance one edge, return 1 ns after it with inputs idle
    task automatic tick();
        @(posedge clk); #1;
        idle();
    endtask

    task automatic peek(input logic [3:0] idx, output logic [15:0] w);
        acc_src = 2; acc_mode = 0; acc_idx = idx;
        #0.2;
        w = acc_addr;
    endtask

    task automatic put(input logic [3:0] idx, input logic [15:0] w);
        half_we = 1; half_idx = idx; half_hi = 1; half_wdata = w[15:8]; tick();
        half_we = 1; half_idx = idx; half_hi = 0; half_wdata = w[7:0];  tick();
    endtask

    task automatic t_reset();
        idle(); rst = 1;
        set_p_en = 1; p_val = 4'd7;
        repeat (3) @(posedge clk);
        #1; rst = 0; idle();
        chk("R1 p_sel", {12'd0, p_sel}, 16'd0);
        chk("R1 x_sel", {12'd0, x_sel}, 16'd0);
        acc_src = 0; acc_mode = 0; #0.2;
        chk("R1 pc address", acc_addr, 16'h0000);
        idle();
    endtask

    task automatic t_sel();
        logic [15:0] w;
        put(4'd5, 16'h1234);
        set_p_en = 1; p_val = 4'd5; tick();
        chk("R4 p_sel", {12'd0, p_sel}, 16'd5);
        acc_src = 0; #0.2;
        chk("R4 pc address", acc_addr, 16'h1234);
        idle();
        put(4'd9, 16'hABCD);
        set_x_en = 1; x_val = 4'd9; tick();
        chk("R5 x_sel", {12'd0, x_sel}, 16'd9);
        acc_src = 1; #0.2;
        chk("R5 data address", acc_addr, 16'hABCD);
        idle();
        // call to r9 and return to r5 by switching selector
        set_p_en = 1; p_val = 4'd9; tick();
        acc_src = 0; #0.2; chk("R4 call", acc_addr, 16'hABCD); idle();
        set_p_en = 1; p_val = 4'd5; tick();
        acc_src = 0; #0.2; chk("R4 return", acc_addr, 16'h1234); idle();
        peek(4'd5, w); chk("R4 r5 untouched", w, 16'h1234);
    endtask

    task automatic t_step();
        logic [15:0] w;
        put(4'd3, 16'h00FF);
        step_op = 1; step_idx = 3; tick();
        peek(4'd3, w); chk("R2 inc carry", w, 16'h0100);
        step_op = 2; step_idx = 3; tick();
        peek(4'd3, w); chk("R2 dec borrow", w, 16'h00FF);
        step_op = 3; step_idx = 3; tick();
        peek(4'd3, w); chk("R2 op3 no effect", w, 16'h00FF);
    endtask

    task automatic t_wrap();
        logic [15:0] w;
        put(4'd7, 16'hFFFF);
        step_op = 1; step_idx = 7; tick();
        peek(4'd7, w); chk("R10 inc wrap", w, 16'h0000);
        step_op = 2; step_idx = 7; tick();
        peek(4'd7, w); chk("R10 dec wrap", w, 16'hFFFF);
    endtask

    task automatic t_half();
        logic [15:0] w;
        put(4'd2, 16'h5566);
        peek(4'd2, w); chk("R3 word assembled", w, 16'h5566);
        half_we = 1; half_hi = 1; half_idx = 2; half_wdata = 8'hA1; tick();
        peek(4'd2, w); chk("R3 high write", w, 16'hA166);
        half_idx = 2; half_hi = 0; #0.2;
        chk("R3 low read", {8'd0, half_rdata}, 16'h0066);
        half_hi = 1; #0.2;
        chk("R3 high read", {8'd0, half_rdata}, 16'h00A1);
        idle();
    endtask

    task automatic t_postinc();
        logic [15:0] w;
        put(4'd4, 16'h2000);
        acc_src = 2; acc_idx = 4; acc_mode = 1; #0.2;
        chk("R6 addr before inc", acc_addr, 16'h2000);
        tick();
        peek(4'd4, w); chk("R6 reg after inc", w, 16'h2001);
        acc_src = 1; acc_mode = 1; #0.2;   // pop through data pointer r9
        chk("R6 pop addr", acc_addr, 16'hABCD);
        tick();
        peek(4'd9, w); chk("R6 pop reg", w, 16'hABCE);
        put(4'd10, 16'hFFFF);
        acc_src = 3; acc_idx = 10; acc_mode = 1; tick();
        peek(4'd10, w); chk("R10 postinc wrap", w, 16'h0000);
    endtask

    task automatic t_predec();
        logic [15:0] w;
        put(4'd6, 16'h0000);
        set_x_en = 1; x_val = 6; tick();
        acc_src = 1; acc_mode = 2; #0.2;
        chk("R7 push addr wraps", acc_addr, 16'hFFFF);
        tick();
        peek(4'd6, w); chk("R7 reg after push", w, 16'hFFFF);
        acc_src = 1; acc_mode = 2; #0.2;
        chk("R7 second push addr", acc_addr, 16'hFFFE);
        tick();
        peek(4'd6, w); chk("R7 reg after second push", w, 16'hFFFE);
    endtask

    task automatic t_priority();
        logic [15:0] w;
        put(4'd8, 16'h1111);
        step_op = 1; step_idx = 8;
        half_we = 1; half_hi = 0; half_idx = 8; half_wdata = 8'h22;
        tick();
        peek(4'd8, w); chk("R8 half beats step", w, 16'h1122);
        step_op = 2; step_idx = 8;
        acc_src = 2; acc_idx = 8; acc_mode = 1;
        tick();
        peek(4'd8, w); chk("R8 step beats access", w, 16'h1121);
    endtask

    task automatic t_plain();
        logic [15:0] w;
        acc_src = 2; acc_idx = 4; acc_mode = 0; tick();
        peek(4'd4, w); chk("R9 mode0 unchanged", w, 16'h2001);
        acc_src = 0; acc_mode = 3; #0.2;
        chk("R9 mode3 addr", acc_addr, 16'h1234);
        tick();
        peek(4'd5, w); chk("R9 mode3 unchanged", w, 16'h1234);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_sel();
        t_step();
        t_wrap();
        t_half();
        t_postinc();
        t_predec();
        t_priority();
        t_plain();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_total++; n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 16'd0, 16'd1);
        finish_run();
    end
endmodule